// File: doc/BRIEF.md
# Eight-Channel Pulse Width Modulator with Pairable Channels

The block drives eight output pins, each from its own 8-bit counter engine with a programmable period and duty value. Two neighbouring channels can be joined so that one 16-bit counter drives a single pin, which gives four 16-bit channels when every pair is joined. Each channel has its own choice of edge-aligned or centre-aligned counting and its own output polarity. The four lower channels share one clock divider setting and the four upper channels share a second one. Each setting divides the bus clock by a power of two.

Software programs the block through a byte-wide write port and a combinational read port. New period and duty values go into holding registers. A running channel copies them into its working registers only at the end of its current period. An emergency shutdown input forces every live pin to a programmable safe level in the same cycle. It also latches a flag that stays set until software clears it.

Register map: 0x00 enable bits, 0x01 polarity bits, 0x02 centre-mode bits, 0x03 pair-join bits (bit k joins channels 2k and 2k+1), 0x04 divider exponent for channels 0..3, 0x05 divider exponent for channels 4..7, 0x06 shutdown control, 0x08+n period of channel n, 0x10+n duty of channel n. Unmapped addresses read as zero and ignore writes.

Top module: `pwm_octet`

## Requirements
- R1: After synchronous reset every pin is low, the shutdown flag output is low, and every mapped register reads 0x00.
- R2: A write to a mapped address changes only that register, and reading the same address returns the written value (divider registers return bits 2:0, the pair register returns bits 3:0).
- R3: In edge-aligned mode with period P>0 and duty D, the channel counter steps 0..P-1 once per divided clock tick and wraps to 0. The channel is active while the counter is below D.
- R4: In centre-aligned mode (centre bit set) the counter climbs to P and falls back to 0, so one period lasts 2·P ticks. The channel is active for 2·D of them, placed symmetrically about the count of zero.
- R5: Duty 0 keeps the channel inactive for good. A duty equal to or above the period keeps it active for good, in both modes.
- R6: Period and duty writes reach a running channel only at the end of its period: the edge-aligned wrap, or the centre-aligned turn at zero. A disabled channel takes them at once.
- R7: Divider exponent N (0..7) makes the channel counters advance once every 2^N bus cycles. Register 0x04 sets the exponent for channels 0..3 and register 0x05 sets it for channels 4..7. All channels share one free-running divide counter.
- R8: With the polarity bit at 1 the pin is high while the channel is active. With the bit at 0 the pin is low while the channel is active.
- R9: With pair bit k set, channels 2k and 2k+1 form one 16-bit channel. Channel 2k holds the high byte of period and duty, and channel 2k+1 holds the low byte. The waveform leaves on pin 2k+1, under that channel's enable, polarity, centre bit and divider group. Pin 2k stays low.
- R10: Register 0x06 holds the shutdown enable in bit 0 and the safe level in bit 1. While bit 0 is 1 and the shutdown input is high, every live pin equals the safe level in that same cycle. While bit 0 is 0, the input has no effect on the pins or the flag.
- R11: Shutdown with the enable set raises the flag one cycle later. The flag is readable in bit 7 of 0x06 and drives the flag output. Writing 1 to bit 7 clears it, but only in a cycle without active shutdown.
- R12: A disabled channel drives its pin low and holds its counter at the start of a period, rising count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| shutdown_i | input | 1 | Emergency shutdown, synchronous to clk_i |
| pwm_o | output | 8 | Channel output pins |
| sd_irq_o | output | 1 | Latched shutdown flag |

## Verification
The bench builds the block with its default parameters: eight channels, byte-wide registers and a 3-bit divider exponent. These defaults give a 7-bit shared divide counter and 16-bit joined counters. A joined pair with a high byte of 1 reaches a 260-tick period, so the high-byte path and the 16-bit comparison are exercised within a few hundred cycles. Divider exponents 1 and 2 on the two groups cover the group split and the stepped counting. A behavioural reference keeps integer counters per channel and predicts every pin and the flag on every clock, including the buffered reloads and the shutdown override.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int NCH    = 8;
    localparam int NPAIR  = NCH / 2;
    localparam int DW     = 8;
    localparam int CW     = 2 * DW;
    localparam int SEL_W  = 3;
    localparam int DIV_W  = (1 << SEL_W) - 1;
    localparam int AW     = 5;
    localparam int IDX_W  = $clog2(NCH);

    localparam logic [AW-1:0] A_EN   = 5'h00;
    localparam logic [AW-1:0] A_POL  = 5'h01;
    localparam logic [AW-1:0] A_CTR  = 5'h02;
    localparam logic [AW-1:0] A_CAT  = 5'h03;
    localparam logic [AW-1:0] A_SELA = 5'h04;
    localparam logic [AW-1:0] A_SELB = 5'h05;
    localparam logic [AW-1:0] A_SD   = 5'h06;
    localparam logic [1:0]    PG_PER = 2'b01;
    localparam logic [1:0]    PG_DUT = 2'b10;

    typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;

    typedef struct packed {
        logic [NCH-1:0]   en;
        logic [NCH-1:0]   pol;
        logic [NCH-1:0]   ctr;
        logic [NPAIR-1:0] cat;
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
        logic             sd_en;
        logic             sd_lvl;
    } pwm_cfg_t;

    // True when the low e bits of the divide counter are all ones.
    function automatic logic tick_hit(input logic [DIV_W-1:0] d, input logic [SEL_W-1:0] e);
        logic hit;
        hit = 1'b1;
        for (int b = 0; b < DIV_W; b++)
            if (b < int'(e) && !d[b]) hit = 1'b0;
        return hit;
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SEL_W-1:0] sel_a_i,
    input  logic [SEL_W-1:0] sel_b_i,
    output logic             tick_a_o,
    output logic             tick_b_o
);
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) div_q <= '0;
        else       div_q <= div_q + 1'b1;
    end

    assign tick_a_o = tick_hit(div_q, sel_a_i);
    assign tick_b_o = tick_hit(div_q, sel_b_i);
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    wr_en_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic                    sd_hit_i,
    output logic [DW-1:0]           rdata_o,
    output pwm_cfg_t                cfg_o,
    output logic [NCH-1:0][DW-1:0]  per_o,
    output logic [NCH-1:0][DW-1:0]  dut_o,
    output logic                    flag_o
);
    logic [IDX_W-1:0] idx;
    logic             clr;

    assign idx = addr_i[IDX_W-1:0];
    assign clr = wr_en_i && addr_i == A_SD && wdata_i[DW-1];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_o  <= '0;
            per_o  <= '0;
            dut_o  <= '0;
            flag_o <= 1'b0;
        end else begin
            flag_o <= sd_hit_i | (flag_o & ~clr);
            if (wr_en_i) begin
                case (addr_i)
                    A_EN:   cfg_o.en    <= wdata_i;
                    A_POL:  cfg_o.pol   <= wdata_i;
                    A_CTR:  cfg_o.ctr   <= wdata_i;
                    A_CAT:  cfg_o.cat   <= wdata_i[NPAIR-1:0];
                    A_SELA: cfg_o.sel_a <= wdata_i[SEL_W-1:0];
                    A_SELB: cfg_o.sel_b <= wdata_i[SEL_W-1:0];
                    A_SD: begin
                        cfg_o.sd_en  <= wdata_i[0];
                        cfg_o.sd_lvl <= wdata_i[1];
                    end
                    default: begin
                        if (addr_i[AW-1:IDX_W] == PG_PER) per_o[idx] <= wdata_i;
                        if (addr_i[AW-1:IDX_W] == PG_DUT) dut_o[idx] <= wdata_i;
                    end
                endcase
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_EN:   rdata_o = cfg_o.en;
            A_POL:  rdata_o = cfg_o.pol;
            A_CTR:  rdata_o = cfg_o.ctr;
            A_CAT:  rdata_o = {{(DW-NPAIR){1'b0}}, cfg_o.cat};
            A_SELA: rdata_o = {{(DW-SEL_W){1'b0}}, cfg_o.sel_a};
            A_SELB: rdata_o = {{(DW-SEL_W){1'b0}}, cfg_o.sel_b};
            A_SD:   rdata_o = {flag_o, {(DW-3){1'b0}}, cfg_o.sd_lvl, cfg_o.sd_en};
            default: begin
                if (addr_i[AW-1:IDX_W] == PG_PER) rdata_o = per_o[idx];
                if (addr_i[AW-1:IDX_W] == PG_DUT) rdata_o = dut_o[idx];
            end
        endcase
    end

    // R11: the flag only drops through a clear write
    p_flag_sticky_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(flag_o) && !$past(clr) |-> flag_o);
    // R11: an active shutdown always leaves the flag set
    p_flag_set_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        sd_hit_i |=> flag_o);
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
    import pwm_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic          center_i,
    input  logic [CW-1:0] per_i,
    input  logic [CW-1:0] dut_i,
    output logic          act_o
);
    logic [CW-1:0] cnt, cnt_nxt, aper, adut;
    dir_e          dir, dir_nxt;
    logic          load;

    always_comb begin
        load    = 1'b0;
        cnt_nxt = cnt + 1'b1;
        dir_nxt = dir;
        if (!center_i) begin
            dir_nxt = DIR_UP;
            if ({1'b0, cnt} + 1'b1 >= {1'b0, aper}) begin
                cnt_nxt = '0;
                load    = 1'b1;
            end
        end else if (aper == '0) begin
            cnt_nxt = '0;
            dir_nxt = DIR_UP;
            load    = 1'b1;
        end else if (dir == DIR_UP) begin
            if (cnt >= aper) begin
                cnt_nxt = cnt - 1'b1;
                dir_nxt = DIR_DOWN;
            end
        end else if (cnt == '0) begin
            dir_nxt = DIR_UP;
            load    = 1'b1;
        end else begin
            cnt_nxt = cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt  <= '0;
            dir  <= DIR_UP;
            aper <= '0;
            adut <= '0;
        end else if (!en_i) begin
            cnt  <= '0;
            dir  <= DIR_UP;
            aper <= per_i;
            adut <= dut_i;
        end else if (tick_i) begin
            cnt <= cnt_nxt;
            dir <= dir_nxt;
            if (load) begin
                aper <= per_i;
                adut <= dut_i;
            end
        end
    end

    always_comb begin
        if (adut == '0)                           act_o = 1'b0;
        else if (center_i && dir == DIR_UP)       act_o = cnt <= adut;
        else                                      act_o = cnt < adut;
    end

    // R6: working period and duty change only at a period end
    p_shadow_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(en_i) && !($past(tick_i) && $past(load)) |-> $stable(aper) && $stable(adut));
    // R7: a running counter moves only on a divider tick
    p_tick_only_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(en_i) && !$past(tick_i) |-> $stable(cnt));
endmodule

// File: rtl/pwm_octet.sv
module pwm_octet
    import pwm_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          shutdown_i,
    output logic [NCH-1:0] pwm_o,
    output logic          sd_irq_o
);
    pwm_cfg_t                cfg;
    logic [NCH-1:0][DW-1:0]  per_q, dut_q;
    logic                    tick_a, tick_b, sd_hit;
    logic [NCH-1:0]          live;

    assign sd_hit = cfg.sd_en & shutdown_i;

    pwm_regfile u_regs (
        .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .sd_hit_i(sd_hit), .rdata_o(rdata_o), .cfg_o(cfg),
        .per_o(per_q), .dut_o(dut_q), .flag_o(sd_irq_o)
    );

    pwm_prescaler u_div (
        .clk_i(clk_i), .rst_i(rst_i), .sel_a_i(cfg.sel_a), .sel_b_i(cfg.sel_b),
        .tick_a_o(tick_a), .tick_b_o(tick_b)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CW-1:0] per_w, dut_w;
        logic          act_w, tick_w;

        if (i % 2 == 1) begin : g_odd
            assign per_w   = cfg.cat[i/2] ? {per_q[i-1], per_q[i]} : {{DW{1'b0}}, per_q[i]};
            assign dut_w   = cfg.cat[i/2] ? {dut_q[i-1], dut_q[i]} : {{DW{1'b0}}, dut_q[i]};
            assign live[i] = cfg.en[i];
        end else begin : g_even
            assign per_w   = {{DW{1'b0}}, per_q[i]};
            assign dut_w   = {{DW{1'b0}}, dut_q[i]};
            assign live[i] = cfg.en[i] & ~cfg.cat[i/2];
        end

        assign tick_w = (i < NCH/2) ? tick_a : tick_b;

        pwm_engine u_eng (
            .clk_i(clk_i), .rst_i(rst_i), .en_i(cfg.en[i]), .tick_i(tick_w),
            .center_i(cfg.ctr[i]), .per_i(per_w), .dut_i(dut_w), .act_o(act_w)
        );

        always_comb begin
            if (!live[i])    pwm_o[i] = 1'b0;
            else if (sd_hit) pwm_o[i] = cfg.sd_lvl;
            else             pwm_o[i] = cfg.pol[i] ? act_w : ~act_w;
        end
    end

    // R10: shutdown puts every live pin at the safe level in the same cycle
    p_sd_force_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        sd_hit |-> (pwm_o & live) == ({NCH{cfg.sd_lvl}} & live));
    // R12: pins of channels that are not live stay low
    p_dead_low_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (pwm_o & ~live) == '0);
endmodule

// File: tb/pwm_octet_test.sv
module pwm_octet_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       shutdown_i = 1'b0;
    logic [7:0] rdata, pwm_o;
    logic       sd_irq;

    int checks = 0, fails = 0;
    bit cmp_on = 0;
    bit wd = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt[8], m_aper[8], m_adut[8], s_per[8], s_dut[8];
    bit m_up[8];
    bit [7:0] m_en, m_pol, m_ctr;
    bit [3:0] m_cat;
    int m_sela, m_selb, m_pre;
    bit m_sden, m_sdlvl, m_flag;

    always #5 clk = ~clk;

    pwm_octet uut (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .shutdown_i(shutdown_i), .pwm_o(pwm_o), .sd_irq_o(sd_irq)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_cnt[i] = 0; m_aper[i] = 0; m_adut[i] = 0; s_per[i] = 0; s_dut[i] = 0; m_up[i] = 1;
            end
            m_en = 0; m_pol = 0; m_ctr = 0; m_cat = 0; m_sela = 0; m_selb = 0;
            m_pre = 0; m_sden = 0; m_sdlvl = 0; m_flag = 0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                int p, d, s;
                bit tk;
                if (i % 2 == 1 && m_cat[i/2]) begin
                    p = s_per[i-1] * 256 + s_per[i];
                    d = s_dut[i-1] * 256 + s_dut[i];
                end else begin
                    p = s_per[i];
                    d = s_dut[i];
                end
                s  = (i < 4) ? m_sela : m_selb;
                tk = (m_pre % (1 << s)) == ((1 << s) - 1);
                if (!m_en[i]) begin
                    m_cnt[i] = 0; m_up[i] = 1; m_aper[i] = p; m_adut[i] = d;
                end else if (tk) begin
                    if (!m_ctr[i]) begin
                        m_up[i] = 1;
                        if (m_cnt[i] + 1 >= m_aper[i]) begin
                            m_cnt[i] = 0; m_aper[i] = p; m_adut[i] = d;
                        end else m_cnt[i]++;
                    end else if (m_aper[i] == 0) begin
                        m_cnt[i] = 0; m_up[i] = 1; m_aper[i] = p; m_adut[i] = d;
                    end else if (m_up[i]) begin
                        if (m_cnt[i] >= m_aper[i]) begin m_up[i] = 0; m_cnt[i]--; end
                        else m_cnt[i]++;
                    end else if (m_cnt[i] == 0) begin
                        m_up[i] = 1; m_cnt[i] = 1; m_aper[i] = p; m_adut[i] = d;
                    end else m_cnt[i]--;
                end
            end
            m_flag = (m_sden && shutdown_i) || (m_flag && !(wr_en && addr == 6 && wdata[7]));
            m_pre = (m_pre + 1) % 128;
            if (wr_en) begin
                case (addr)
                    0: m_en = wdata;
                    1: m_pol = wdata;
                    2: m_ctr = wdata;
                    3: m_cat = wdata[3:0];
                    4: m_sela = wdata[2:0];
                    5: m_selb = wdata[2:0];
                    6: begin m_sden = wdata[0]; m_sdlvl = wdata[1]; end
                    default: begin
                        if (addr >= 8 && addr < 16) s_per[addr-8] = wdata;
                        else if (addr >= 16 && addr < 24) s_dut[addr-16] = wdata;
                    end
                endcase
            end
        end
    end

    function automatic bit [7:0] exp_pins();
        bit [7:0] r;
        for (int i = 0; i < 8; i++) begin
            bit a;
            if (m_adut[i] == 0) a = 0;
            else if (m_ctr[i] && m_up[i]) a = m_cnt[i] <= m_adut[i];
            else a = m_cnt[i] < m_adut[i];
            if ((i % 2 == 0 && m_cat[i/2]) || !m_en[i]) r[i] = 0;
            else if (m_sden && shutdown_i) r[i] = m_sdlvl;
            else r[i] = m_pol[i] ? a : !a;
        end
        return r;
    endfunction

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (pwm_o !== exp_pins() || sd_irq !== m_flag) begin
                fails++;
                $display("FAIL %s pins/flag at %0t: actual %h/%b expected %h/%b",
                         cur_req, $time, pwm_o, sd_irq, exp_pins(), m_flag);
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 0;
    endtask

    task automatic rd(logic [4:0] a, logic [7:0] exp, string req);
        @(posedge clk); #2;
        addr = a;
        @(negedge clk);
        chk(req, rdata, exp);
    endtask

    task automatic run();
        repeat (4) @(posedge clk);
        #2 rst = 0;
        cmp_on = 1;
        @(negedge clk);
        chk("R1", pwm_o, 8'h00);
        chk("R1", {7'b0, sd_irq}, 8'h00);
        for (int a = 0; a < 7; a++) rd(a[4:0], 8'h00, "R1");
        rd(5'h08, 8'h00, "R1");
        rd(5'h17, 8'h00, "R1");

        cur_req = "R2";
        wr(5'h08, 8'd5); wr(5'h10, 8'd2);
        rd(5'h08, 8'd5, "R2"); rd(5'h10, 8'd2, "R2");
        wr(5'h04, 8'hFB); rd(5'h04, 8'h03, "R2"); wr(5'h04, 8'h00);
        rd(5'h09, 8'h00, "R2");
        wr(5'h01, 8'h01); wr(5'h00, 8'h01);
        cur_req = "R3"; repeat (30) @(posedge clk);
        cur_req = "R6"; wr(5'h10, 8'd4); repeat (20) @(posedge clk);
        wr(5'h08, 8'd3); repeat (12) @(posedge clk);

        cur_req = "R8";
        wr(5'h09, 8'd4); wr(5'h11, 8'd1); wr(5'h00, 8'h03);
        repeat (20) @(posedge clk);

        cur_req = "R4";
        wr(5'h0A, 8'd4); wr(5'h12, 8'd2); wr(5'h02, 8'h04);
        wr(5'h01, 8'h05); wr(5'h00, 8'h07);
        repeat (40) @(posedge clk);
        wr(5'h12, 8'd1); repeat (24) @(posedge clk);

        cur_req = "R5";
        wr(5'h0B, 8'd6); wr(5'h13, 8'd0); wr(5'h0C, 8'd6); wr(5'h14, 8'd9);
        wr(5'h01, 8'h1D); wr(5'h00, 8'h1F);
        repeat (15) @(posedge clk);
        @(negedge clk); chk("R5", {6'b0, pwm_o[4:3]}, 8'h02);
        wr(5'h02, 8'h1C); repeat (20) @(posedge clk);

        cur_req = "R7";
        wr(5'h04, 8'h01); wr(5'h0D, 8'd3); wr(5'h15, 8'd1); wr(5'h05, 8'h02);
        wr(5'h01, 8'h3D); wr(5'h00, 8'h3F);
        repeat (60) @(posedge clk);

        cur_req = "R9";
        wr(5'h05, 8'h00);
        wr(5'h0E, 8'd1); wr(5'h0F, 8'd4); wr(5'h16, 8'd0); wr(5'h17, 8'd130);
        wr(5'h03, 8'h08); wr(5'h01, 8'hBD); wr(5'h00, 8'hFF);
        repeat (600) @(posedge clk);
        @(negedge clk); chk("R9", {7'b0, pwm_o[6]}, 8'h00);

        cur_req = "R10";
        wr(5'h06, 8'h03);
        @(posedge clk); #2 shutdown_i = 1;
        @(negedge clk); chk("R10", pwm_o, 8'hBF);
        repeat (4) @(posedge clk);
        #2 shutdown_i = 0;
        cur_req = "R11";
        rd(5'h06, 8'h83, "R11");
        chk("R11", {7'b0, sd_irq}, 8'h01);
        @(posedge clk); #2 shutdown_i = 1;
        wr(5'h06, 8'h83);
        shutdown_i = 0;
        rd(5'h06, 8'h83, "R11");
        wr(5'h06, 8'h83);
        rd(5'h06, 8'h03, "R11");
        chk("R11", {7'b0, sd_irq}, 8'h00);

        cur_req = "R10";
        wr(5'h06, 8'h02);
        @(posedge clk); #2 shutdown_i = 1;
        repeat (10) @(posedge clk);
        #2 shutdown_i = 0;
        rd(5'h06, 8'h02, "R10");

        cur_req = "R12";
        wr(5'h00, 8'hFE);
        repeat (20) @(posedge clk);
        @(negedge clk); chk("R12", {7'b0, pwm_o[0]}, 8'h00);
        wr(5'h00, 8'hFF);
        repeat (20) @(posedge clk);
    endtask

    initial begin
        fork
            run();
            begin repeat (150000) @(posedge clk); wd = 1; end
        join_any
        disable fork;
        if (wd) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule